// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This block decides when a phase-locked loop may safely drive the system clock. It runs from the reference oscillator clock. It turns the PLL on when a start request arrives and keeps the system clock on the oscillator. It then waits for the PLL's raw lock indication. It selects the PLL only after that indication has held without a break for a programmable number of phase-detector periods. One phase-detector period is the reference clock period multiplied by a programmable reference divider. An overall timeout starts when the PLL is enabled. If the timeout expires, the attempt is abandoned with a sticky failure flag.

Some PLLs report lock before the loop has settled, and an unlocked PLL can sweep its frequency quickly enough to upset any logic it clocks. Lock is therefore distrusted in two ways. A drop during qualification discards the progress made so far, but the overall timeout keeps running. A drop after selection takes the PLL off the system clock at once, records the loss and starts a fresh qualification under a fresh timeout. The clock multiplexer that acts on the select output, the analog loop and its filter lie outside this block.

Top module: `pllq_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no start request, `pll_en_o`, `pll_sel_o`, `done_o`, `fail_o` and `lost_o` are all 0.
- R2: The time base ticks once every `ref_div_i` reference cycles; a `ref_div_i` of 0 acts as 1.
- R3: In the cycle after a start request, `pll_en_o` and `pll_sel_o` are 0. `pll_en_o` rises one phase-detector period later, and `pll_sel_o` stays 0 meanwhile.
- R4: `lock_raw_i` passes through a two-flop synchronizer. `pll_sel_o` never rises until the synchronized lock has held for `qual_i` consecutive periods. A `qual_i` of 0 selects 10 periods.
- R5: A lock drop during qualification returns the block to waiting for lock, and the qualification count restarts from zero.
- R6: A timeout of `tmo_i` periods (0 acts as 1) is counted from PLL enable and is not reset by lock drops during acquisition. When it expires, `fail_o` rises, `pll_en_o` falls and `pll_sel_o` stays 0.
- R7: `fail_o` holds until reset or a new start request, and a start request clears it on the next cycle.
- R8: On entry to the selected state, `done_o` is high for exactly one cycle and `pll_sel_o` is high. `pll_sel_o` implies `pll_en_o`.
- R9: If lock drops while selected, `pll_sel_o` falls two cycles after `lock_raw_i` falls. `lost_o` is then set and holds until the next start request. The block requalifies under a fresh timeout, with `pll_en_o` kept high.
- R10: A start request in any state restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) request, one cycle |
| lock_raw_i | input | 1 | Raw lock indication from the PLL, asynchronous |
| ref_div_i | input | DIV_W (8) | Reference divider: cycles per phase-detector period |
| qual_i | input | QUAL_W (8) | Consecutive lock periods required, 0 means 10 |
| tmo_i | input | TMO_W (16) | Overall timeout in periods |
| pll_en_o | output | 1 | PLL enable |
| pll_sel_o | output | 1 | Select PLL as system clock |
| done_o | output | 1 | One-cycle pulse on selection |
| fail_o | output | 1 | Sticky lock failure |
| lost_o | output | 1 | Lock was lost after selection |

## Verification
A wrong state shows up first at `pll_en_o` and `pll_sel_o`. Entering the selected state too early shows as `pll_sel_o` rising before the requested number of periods since lock was last seen. That lower bound is checked for every divider and count in the vector table, and again after a deliberate lock drop. A timeout counter that restarts on a lock drop shows as a missing `fail_o` while lock chatters. A timeout that is not refreshed after a loss shows as `fail_o` where a second `done_o` should appear. Each of these appears within a few tens of periods of the stimulus.

// File: rtl/pllq_pkg.sv
package pllq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ENABLE = 3'd1,
      ST_WAIT   = 3'd2,
      ST_QUAL   = 3'd3,
      ST_SEL    = 3'd4,
      ST_FAIL   = 3'd5
   } pllq_state_e;

endpackage

// File: rtl/pllq_sync.sv
module pllq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pllq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pllq_tick.sv
module pllq_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("pllq_tick: DIV_W must be positive");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] last_val;

   assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
   assign last_val = div_eff - DIV_W'(1);
   assign tick_o   = !clr_i && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/pllq_count.sv
module pllq_count #(
   parameter int W        = 8,
   parameter int ZERO_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   input  logic [W-1:0] lim_i,
   output logic         hit_o
);
   generate
      if (ZERO_VAL < 1 || ZERO_VAL >= (1 << W)) begin : g_bad_zero
         $error("pllq_count: ZERO_VAL must fit in W bits and be positive");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] lim_eff;

   assign lim_eff = (lim_i == '0) ? W'(ZERO_VAL) : lim_i;
   assign hit_o   = inc_i && !clr_i && (cnt_q == (lim_eff - W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (hit_o)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/pllq_fsm.sv
module pllq_fsm
   import pllq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        lock_i,
   input  logic        tick_i,
   input  logic        qual_hit_i,
   input  logic        tmo_hit_i,
   output logic        tick_clr_o,
   output logic        qual_clr_o,
   output logic        qual_inc_o,
   output logic        tmo_clr_o,
   output logic        tmo_inc_o,
   output logic        pll_en_o,
   output logic        pll_sel_o,
   output logic        done_o,
   output logic        fail_o,
   output logic        lost_o
);
   pllq_state_e state_q, state_d;
   logic        done_q, lost_q;

   always_comb begin
      state_d = state_q;
      if (start_i) begin
         state_d = ST_ENABLE;
      end else begin
         case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_ENABLE: if (tick_i) state_d = ST_WAIT;
            ST_WAIT: begin
               if (tmo_hit_i)   state_d = ST_FAIL;
               else if (lock_i) state_d = ST_QUAL;
            end
            ST_QUAL: begin
               if (tmo_hit_i)       state_d = ST_FAIL;
               else if (!lock_i)    state_d = ST_WAIT;
               else if (qual_hit_i) state_d = ST_SEL;
            end
            ST_SEL:    if (!lock_i) state_d = ST_WAIT;
            ST_FAIL:   state_d = ST_FAIL;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   assign tick_clr_o = start_i || (state_q == ST_IDLE) || (state_q == ST_FAIL);
   assign qual_inc_o = (state_q == ST_QUAL) && lock_i && tick_i;
   assign qual_clr_o = start_i || (state_q != ST_QUAL) || !lock_i;
   assign tmo_inc_o  = ((state_q == ST_WAIT) || (state_q == ST_QUAL)) && tick_i;
   assign tmo_clr_o  = start_i || !((state_q == ST_WAIT) || (state_q == ST_QUAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         lost_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_QUAL) && (state_d == ST_SEL);
         if (start_i)
            lost_q <= 1'b0;
         else if ((state_q == ST_SEL) && !lock_i)
            lost_q <= 1'b1;
      end
   end

   assign pll_en_o  = (state_q == ST_WAIT) || (state_q == ST_QUAL) || (state_q == ST_SEL);
   assign pll_sel_o = (state_q == ST_SEL) && lock_i;
   assign done_o    = done_q;
   assign fail_o    = (state_q == ST_FAIL);
   assign lost_o    = lost_q;
endmodule

// File: rtl/pllq_ctrl.sv
module pllq_ctrl #(
   parameter int DIV_W        = 8,
   parameter int QUAL_W       = 8,
   parameter int TMO_W        = 16,
   parameter int QUAL_DEFAULT = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              lock_raw_i,
   input  logic [DIV_W-1:0]  ref_div_i,
   input  logic [QUAL_W-1:0] qual_i,
   input  logic [TMO_W-1:0]  tmo_i,
   output logic              pll_en_o,
   output logic              pll_sel_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              lost_o
);
   generate
      if (QUAL_W < 4 || QUAL_DEFAULT >= (1 << QUAL_W)) begin : g_bad_qual
         $error("pllq_ctrl: QUAL_W too small for QUAL_DEFAULT");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("pllq_ctrl: TMO_W must be at least 2");
      end
   endgenerate

   logic lock_s, tick;
   logic tick_clr, qual_clr, qual_inc, qual_hit;
   logic tmo_clr, tmo_inc, tmo_hit;

   pllq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d_i (lock_raw_i), .q_o (lock_s)
   );

   pllq_tick #(.DIV_W(DIV_W)) u_tick (
      .clk (clk), .rst_n (rst_n), .clr_i (tick_clr), .div_i (ref_div_i), .tick_o (tick)
   );

   pllq_count #(.W(QUAL_W), .ZERO_VAL(QUAL_DEFAULT)) u_qual (
      .clk (clk), .rst_n (rst_n), .clr_i (qual_clr), .inc_i (qual_inc),
      .lim_i (qual_i), .hit_o (qual_hit)
   );

   pllq_count #(.W(TMO_W), .ZERO_VAL(1)) u_tmo (
      .clk (clk), .rst_n (rst_n), .clr_i (tmo_clr), .inc_i (tmo_inc),
      .lim_i (tmo_i), .hit_o (tmo_hit)
   );

   pllq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .lock_i     (lock_s),
      .tick_i     (tick),
      .qual_hit_i (qual_hit),
      .tmo_hit_i  (tmo_hit),
      .tick_clr_o (tick_clr),
      .qual_clr_o (qual_clr),
      .qual_inc_o (qual_inc),
      .tmo_clr_o  (tmo_clr),
      .tmo_inc_o  (tmo_inc),
      .pll_en_o   (pll_en_o),
      .pll_sel_o  (pll_sel_o),
      .done_o     (done_o),
      .fail_o     (fail_o),
      .lost_o     (lost_o)
   );
endmodule

// File: rtl/pllq_ctrl_chk.sv
module pllq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic pll_en_o,
   input logic pll_sel_o,
   input logic done_o,
   input logic fail_o,
   input logic lost_o
);
   // R8
   sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_sel_o |-> pll_en_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(!pll_sel_o));

   // R6
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> (!pll_sel_o && !pll_en_o));

   // R7
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !start_i) |=> fail_o);

   // R3
   start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!pll_en_o && !pll_sel_o && !fail_o && !lost_o));

   // R9
   lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_o && !start_i) |=> lost_o);
endmodule

bind pllq_ctrl pllq_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .pll_en_o  (pll_en_o),
   .pll_sel_o (pll_sel_o),
   .done_o    (done_o),
   .fail_o    (fail_o),
   .lost_o    (lost_o)
);

// File: tb/pllq_ctrl_bench.sv
module pllq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        lock_raw_i = 1'b0;
   logic [7:0]  ref_div_i = 8'd1;
   logic [7:0]  qual_i = 8'd10;
   logic [15:0] tmo_i = 16'd1000;
   logic        pll_en_o, pll_sel_o, done_o, fail_o, lost_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_total = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pllq_ctrl u_pllq_ctrl (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .lock_raw_i (lock_raw_i),
      .ref_div_i (ref_div_i), .qual_i (qual_i), .tmo_i (tmo_i),
      .pll_en_o (pll_en_o), .pll_sel_o (pll_sel_o), .done_o (done_o),
      .fail_o (fail_o), .lost_o (lost_o)
   );

   // columns: divider, qual, timeout, lock held, expect done (else fail)
   localparam int NVEC = 6;
   localparam int VECS [0:NVEC-1][0:4] = '{
      '{4, 10, 1000, 1, 1},
      '{1, 12, 100,  1, 1},
      '{3, 10, 20,   0, 0},
      '{2, 30, 20,   1, 0},
      '{5, 15, 200,  1, 1},
      '{2, 0,  500,  1, 1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
         summary();
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start_i = 1'b0;
      lock_raw_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // waits until done or fail; returns cycles elapsed
   task automatic wait_end(input int limit, output int cyc);
      cyc = 0;
      while (!done_o && !fail_o && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      int cyc, lo, hi, d, q, t, t_rel;

      // R1: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check({pll_en_o, pll_sel_o, done_o, fail_o, lost_o} == 5'b0, "R1 in reset",
            {pll_en_o, pll_sel_o, done_o, fail_o, lost_o}, 0);
      rst_n = 1'b1;
      lock_raw_i = 1'b1;
      repeat (6) @(negedge clk);
      check({pll_en_o, pll_sel_o, done_o, fail_o, lost_o} == 5'b0, "R1 idle no start",
            {pll_en_o, pll_sel_o, done_o, fail_o, lost_o}, 0);

      // Vector table: R2 divider timing, R4 qualification length, R6 timeout
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         d = VECS[v][0];
         q = (VECS[v][1] == 0) ? 10 : VECS[v][1];
         t = VECS[v][2];
         ref_div_i = 8'(VECS[v][0]);
         qual_i = 8'(VECS[v][1]);
         tmo_i = 16'(VECS[v][2]);
         lock_raw_i = VECS[v][3][0];
         pulse_start();
         check(!pll_en_o && !pll_sel_o, "R3 enable low after start", pll_en_o, 0);
         wait_end(20000, cyc);
         if (VECS[v][4] != 0) begin
            lo = q * d;
            hi = (q + 3) * d + 8;
            check(done_o && !fail_o, "R4 selection reached", done_o, 1);
            check(cyc >= lo && cyc <= hi, "R2 R4 selection time", cyc, lo);
            @(negedge clk);
            check(!done_o && pll_sel_o && pll_en_o, "R8 done one cycle, sel held",
                  {done_o, pll_sel_o, pll_en_o}, 3'b011);
         end else begin
            lo = t * d;
            hi = (t + 2) * d + 8;
            check(fail_o && !done_o, "R6 timeout failure", fail_o, 1);
            check(cyc >= lo && cyc <= hi, "R2 R6 timeout time", cyc, lo);
            check(!pll_en_o && !pll_sel_o, "R6 pll off on fail", pll_en_o, 0);
         end
      end

      // R3: enable low for one period then high
      do_reset();
      ref_div_i = 8'd6; qual_i = 8'd10; tmo_i = 16'd1000; lock_raw_i = 1'b0;
      pulse_start();
      repeat (3) @(negedge clk);
      check(!pll_en_o, "R3 enable still low within first period", pll_en_o, 0);
      repeat (6) @(negedge clk);
      check(pll_en_o && !pll_sel_o, "R3 enable high after one period", pll_en_o, 1);

      // R5: lock drop during qualification restarts the count
      do_reset();
      ref_div_i = 8'd2; qual_i = 8'd10; tmo_i = 16'd1000; lock_raw_i = 1'b1;
      pulse_start();
      repeat (12) @(negedge clk);
      lock_raw_i = 1'b0;
      repeat (4) @(negedge clk);
      check(!pll_sel_o && pll_en_o && !fail_o, "R5 back to waiting", pll_sel_o, 0);
      lock_raw_i = 1'b1;
      wait_end(2000, t_rel);
      check(done_o, "R5 selection after drop", done_o, 1);
      check(t_rel >= 20, "R5 full requalification", t_rel, 20);

      // R9: loss after selection, fresh timeout
      do_reset();
      ref_div_i = 8'd2; qual_i = 8'd10; tmo_i = 16'd15; lock_raw_i = 1'b1;
      pulse_start();
      wait_end(2000, cyc);
      check(done_o, "R9 first selection", done_o, 1);
      repeat (3) @(negedge clk);
      lock_raw_i = 1'b0;
      @(negedge clk);
      check(pll_sel_o, "R9 sel held one cycle (sync)", pll_sel_o, 1);
      @(negedge clk);
      check(!pll_sel_o, "R9 sel dropped", pll_sel_o, 0);
      @(negedge clk);
      check(lost_o && pll_en_o && !fail_o, "R9 lost flag, pll on",
            {lost_o, pll_en_o, fail_o}, 3'b110);
      lock_raw_i = 1'b1;
      wait_end(2000, cyc);
      check(done_o && !fail_o, "R9 requalified under fresh timeout", done_o, 1);
      check(lost_o, "R9 lost flag held", lost_o, 1);

      // R10: start while selected restarts; clears lost
      @(negedge clk);
      pulse_start();
      check(!pll_sel_o && !pll_en_o && !lost_o, "R10 restart from selected",
            {pll_sel_o, pll_en_o, lost_o}, 0);

      // R6: timeout keeps running across lock chatter
      do_reset();
      ref_div_i = 8'd1; qual_i = 8'd10; tmo_i = 16'd30; lock_raw_i = 1'b1;
      pulse_start();
      cyc = 0;
      while (!fail_o && !done_o && cyc < 300) begin
         lock_raw_i = ((cyc % 10) < 7);
         @(negedge clk);
         cyc++;
      end
      check(fail_o && !done_o, "R6 chatter leads to failure", fail_o, 1);
      check(cyc <= 45, "R6 timeout not reset by drops", cyc, 45);

      // R7: failure sticky, then cleared by start
      lock_raw_i = 1'b1;
      repeat (40) @(negedge clk);
      check(fail_o && !pll_sel_o && !pll_en_o, "R7 fail sticky", fail_o, 1);
      pulse_start();
      check(!fail_o, "R7 start clears fail", fail_o, 0);
      tmo_i = 16'd1000;
      wait_end(2000, cyc);
      check(done_o, "R7 recovery after fail", done_o, 1);

      summary();
   end
endmodule